// File: doc/BRIEF.md
# I2C Bus Stuck-Line Recovery Controller

This block sits next to an I2C controller and frees the bus when one of its lines has been held low. It samples the SCL and SDA line levels through a synchronizer and glitch filter, and between recoveries it passes the controller's drive-low enables straight to the pads. A recovery sequence starts on a host request or when SCL stays low longer than a programmed clock-low timeout.

When a sequence starts, the block looks at both filtered lines. If SDA is low while SCL is high, a target is holding data. The block takes over the open-drain drives, leaves SDA released and clocks SCL nine times. Each pulse has a high phase and a low phase of `PHASE_CYC` cycles. The block then hands the drives back to the controller, waits for the filter to settle and samples SDA again. If SDA is free, it issues a STOP condition. If SDA is still low, it resets the controller and reports failure. If SCL is low at the start, clocking cannot help. The block resets the controller instead, and if SCL is still low afterwards it raises a request for a hardware reset of the target.

Each sequence ends with a one-cycle `done` pulse. A 2-bit result is valid from the `done` cycle until the next sequence ends. Result codes: 0 = released, 1 = SDA still stuck, 2 = SCL stuck at start, 3 = clock-low timeout.

States: IDLE, SAMPLE, PULSE_HI, PULSE_LO, SETTLE_SDA, CHECK_SDA, STOP_SETUP, STOP_RISE, CTRL_RESET, SETTLE_SCL, VERIFY_SCL, DONE. The transitions are:
- IDLE→CTRL_RESET on a timeout event.
- IDLE→SAMPLE on a request.
- SAMPLE→CTRL_RESET when SCL is low.
- SAMPLE→PULSE_HI when SDA is low.
- SAMPLE→STOP_SETUP when both lines are high.
- PULSE_HI→PULSE_LO after a phase.
- PULSE_LO→PULSE_HI after a phase, or PULSE_LO→SETTLE_SDA after the ninth pulse.
- SETTLE_SDA→CHECK_SDA after the settle time.
- CHECK_SDA→STOP_SETUP when SDA is high, CHECK_SDA→CTRL_RESET when SDA is low.
- STOP_SETUP→STOP_RISE→DONE, one phase each.
- CTRL_RESET→SETTLE_SCL→VERIFY_SCL→DONE.
- DONE→IDLE.

Top module: `bus_unstick_ctrl`

## Requirements
- R1: While idle, `scl_drive_low` equals `ctrl_scl_low` and `sda_drive_low` equals `ctrl_sda_low`.
- R2: A line level that lasts fewer than `FILT_CYC` cycles is ignored for every decision, including the start-of-sequence sample.
- R3: If filtered SCL is low at the start sample, no SCL pulse is generated. `ctrl_rst` is high for exactly `RST_CYC` consecutive cycles, both block drives stay released while `ctrl_rst` is high, and the result is 2.
- R4: If SDA is low and SCL is high at the start sample, exactly `PULSES` (9) SCL drive-low pulses are produced with SDA released. Each low phase lasts `PHASE_CYC` cycles.
- R5: If SDA reads high after the pulses, a STOP follows: the SDA drive falls while the SCL drive is released. The result is 0 and there is no controller reset.
- R6: If SDA still reads low after the pulses, one controller reset pulse is issued, no STOP is issued, and the result is 1.
- R7: `timeout_flag` rises after filtered SCL has been low for `TMO_CYC` cycles, and not for shorter lows.
- R8: A timeout seen while idle runs a controller reset without any clocking, and the result is 3.
- R9: If SCL is still low after a controller reset, `target_rst_req` goes high. It stays high until filtered SCL reads high while idle.
- R10: A request made while a sequence is busy has no effect (one `done` per sequence), and every new request after idle re-runs the whole sequence.
- R11: `done` is high for exactly one cycle per sequence, and `result` is valid in that cycle.
- R12: With both lines high at the start sample, no pulses and no reset are issued, a STOP is issued, and the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| ctrl_scl_low | input | 1 | Controller's SCL drive-low enable |
| ctrl_sda_low | input | 1 | Controller's SDA drive-low enable |
| recover_req | input | 1 | Host request to run a recovery sequence |
| scl_drive_low | output | 1 | SCL pad drive-low enable |
| sda_drive_low | output | 1 | SDA pad drive-low enable |
| ctrl_rst | output | 1 | Controller reset pulse |
| target_rst_req | output | 1 | Request for a target hardware reset |
| timeout_flag | output | 1 | SCL held low past the timeout |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| result | output | 2 | Outcome code of the last sequence |

## Verification
A wrong branch at the start sample shows up at the pads within one cycle. Examples are SCL being clocked while it was already low, or the pulse path being skipped. The error then appears as a pulse count other than nine, or as a `ctrl_rst` rise where none belongs. A miscounted phase or pulse counter appears as a wrong low-phase length or a wrong edge total by the end of the sequence. A bad check or verify decision appears only at `done`, as a wrong result code, a missing STOP edge or a misset `target_rst_req`, a few filter delays after the last pulse. A broken timeout counter moves the `timeout_flag` rise away from the `TMO_CYC` window.

// File: rtl/bus_unstick_pkg.sv
`timescale 1ns/1ps
package bus_unstick_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_PULSE_HI,
        ST_PULSE_LO,
        ST_SETTLE_SDA,
        ST_CHECK_SDA,
        ST_STOP_SETUP,
        ST_STOP_RISE,
        ST_CTRL_RESET,
        ST_SETTLE_SCL,
        ST_VERIFY_SCL,
        ST_DONE
    } unstick_state_e;

    typedef enum logic [1:0] {
        RES_RELEASED  = 2'd0,
        RES_SDA_STUCK = 2'd1,
        RES_SCL_STUCK = 2'd2,
        RES_TIMEOUT   = 2'd3
    } unstick_res_e;

endpackage

// File: rtl/unstick_filter.sv
`timescale 1ns/1ps
module unstick_filter #(
    parameter int LANES    = 2,
    parameter int FILT_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw,
    output logic [LANES-1:0] clean
);
    localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic          s1, s2, q;
        logic [CW-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1  <= 1'b1;
                s2  <= 1'b1;
                q   <= 1'b1;
                cnt <= '0;
            end else begin
                s1 <= raw[g];
                s2 <= s1;
                if (s2 == q) begin
                    cnt <= '0;
                end else if (cnt == CW'(FILT_CYC - 1)) begin
                    q   <= s2;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end

        assign clean[g] = q;
    end
endmodule

// File: rtl/unstick_lowwatch.sv
`timescale 1ns/1ps
module unstick_lowwatch #(
    parameter int TMO_CYC = 6_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_low,
    input  logic count_en,
    output logic tmo_flag,
    output logic tmo_evt
);
    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt;
    logic          flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            flag_q <= 1'b0;
        end else begin
            flag_q <= tmo_flag;
            if (!scl_low || !count_en)
                cnt <= '0;
            else if (cnt != CW'(TMO_CYC))
                cnt <= cnt + CW'(1);
        end
    end

    assign tmo_flag = (cnt == CW'(TMO_CYC));
    assign tmo_evt  = tmo_flag && !flag_q;
endmodule

// File: rtl/unstick_seq.sv
`timescale 1ns/1ps
module unstick_seq
    import bus_unstick_pkg::*;
#(
    parameter int PHASE_CYC  = 1000,
    parameter int PULSES     = 9,
    parameter int RST_CYC    = 16,
    parameter int SETTLE_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic       req,
    input  logic       tmo_evt,
    output logic       own,
    output logic       scl_low,
    output logic       sda_low,
    output logic       ctrl_rst,
    output logic       busy,
    output logic       done,
    output logic       tgt_req,
    output logic [1:0] result
);
    localparam int TMAX_A = (PHASE_CYC > RST_CYC) ? PHASE_CYC : RST_CYC;
    localparam int TMAX   = (TMAX_A > SETTLE_CYC) ? TMAX_A : SETTLE_CYC;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int PW     = $clog2(PULSES + 1);

    unstick_state_e state, nxt;
    unstick_res_e   res_n;
    logic [TW-1:0]  tmr, lim;
    logic [PW-1:0]  pcnt;
    logic           tmr_end, last_pulse;

    always_comb begin
        unique case (state)
            ST_PULSE_HI, ST_PULSE_LO,
            ST_STOP_SETUP, ST_STOP_RISE:   lim = TW'(PHASE_CYC);
            ST_CTRL_RESET:                 lim = TW'(RST_CYC);
            ST_SETTLE_SDA, ST_SETTLE_SCL:  lim = TW'(SETTLE_CYC);
            default:                       lim = TW'(1);
        endcase
    end

    assign tmr_end    = (tmr == lim - TW'(1));
    assign last_pulse = (pcnt == PW'(PULSES - 1));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (tmo_evt)  nxt = ST_CTRL_RESET;
                else if (req) nxt = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (!scl_f)      nxt = ST_CTRL_RESET;
                else if (!sda_f) nxt = ST_PULSE_HI;
                else             nxt = ST_STOP_SETUP;
            end
            ST_PULSE_HI:   if (tmr_end) nxt = ST_PULSE_LO;
            ST_PULSE_LO:   if (tmr_end) nxt = last_pulse ? ST_SETTLE_SDA : ST_PULSE_HI;
            ST_SETTLE_SDA: if (tmr_end) nxt = ST_CHECK_SDA;
            ST_CHECK_SDA:  nxt = sda_f ? ST_STOP_SETUP : ST_CTRL_RESET;
            ST_STOP_SETUP: if (tmr_end) nxt = ST_STOP_RISE;
            ST_STOP_RISE:  if (tmr_end) nxt = ST_DONE;
            ST_CTRL_RESET: if (tmr_end) nxt = ST_SETTLE_SCL;
            ST_SETTLE_SCL: if (tmr_end) nxt = ST_VERIFY_SCL;
            ST_VERIFY_SCL: nxt = ST_DONE;
            ST_DONE:       nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // timers, pulse counter, outcome bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr     <= '0;
            pcnt    <= '0;
            res_n   <= RES_RELEASED;
            result  <= 2'd0;
            tgt_req <= 1'b0;
        end else begin
            if (nxt != state)  tmr <= '0;
            else if (!tmr_end) tmr <= tmr + TW'(1);

            if (state == ST_SAMPLE)
                pcnt <= '0;
            else if (state == ST_PULSE_LO && tmr_end)
                pcnt <= pcnt + PW'(1);

            if (state == ST_IDLE && tmo_evt)
                res_n <= RES_TIMEOUT;
            else if (state == ST_SAMPLE)
                res_n <= !scl_f ? RES_SCL_STUCK : RES_RELEASED;
            else if (state == ST_CHECK_SDA && !sda_f)
                res_n <= RES_SDA_STUCK;

            if (nxt == ST_DONE && state != ST_DONE)
                result <= res_n;

            if (state == ST_VERIFY_SCL && !scl_f)
                tgt_req <= 1'b1;
            else if (state == ST_IDLE && scl_f)
                tgt_req <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        own      = 1'b0;
        scl_low  = 1'b0;
        sda_low  = 1'b0;
        ctrl_rst = 1'b0;
        done     = 1'b0;
        busy     = (state != ST_IDLE);
        unique case (state)
            ST_PULSE_HI:   own = 1'b1;
            ST_PULSE_LO:   begin own = 1'b1; scl_low = 1'b1; end
            ST_STOP_SETUP: begin own = 1'b1; scl_low = 1'b1; sda_low = 1'b1; end
            ST_STOP_RISE:  begin own = 1'b1; sda_low = 1'b1; end
            ST_CTRL_RESET: begin own = 1'b1; ctrl_rst = 1'b1; end
            ST_SETTLE_SCL, ST_VERIFY_SCL: own = 1'b1;
            ST_DONE:       done = 1'b1;
            default:       ;
        endcase
    end
endmodule

// File: rtl/bus_unstick_ctrl.sv
`timescale 1ns/1ps
module bus_unstick_ctrl #(
    parameter int PHASE_CYC = 1000,
    parameter int PULSES    = 9,
    parameter int FILT_CYC  = 4,
    parameter int RST_CYC   = 16,
    parameter int TMO_CYC   = 6_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       ctrl_scl_low,
    input  logic       ctrl_sda_low,
    input  logic       recover_req,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    output logic       ctrl_rst,
    output logic       target_rst_req,
    output logic       timeout_flag,
    output logic       busy,
    output logic       done,
    output logic [1:0] result
);
    localparam int SETTLE_CYC = FILT_CYC + 4;

    logic [1:0] clean;
    logic       scl_f, sda_f;
    logic       own, seq_scl_low, seq_sda_low, tmo_evt;

    unstick_filter #(.LANES(2), .FILT_CYC(FILT_CYC)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({sda_in, scl_in}),
        .clean (clean)
    );

    assign scl_f = clean[0];
    assign sda_f = clean[1];

    unstick_lowwatch #(.TMO_CYC(TMO_CYC)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_low  (!scl_f),
        .count_en (!(own && seq_scl_low)),
        .tmo_flag (timeout_flag),
        .tmo_evt  (tmo_evt)
    );

    unstick_seq #(
        .PHASE_CYC  (PHASE_CYC),
        .PULSES     (PULSES),
        .RST_CYC    (RST_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .req      (recover_req),
        .tmo_evt  (tmo_evt),
        .own      (own),
        .scl_low  (seq_scl_low),
        .sda_low  (seq_sda_low),
        .ctrl_rst (ctrl_rst),
        .busy     (busy),
        .done     (done),
        .tgt_req  (target_rst_req),
        .result   (result)
    );

    assign scl_drive_low = own ? seq_scl_low : ctrl_scl_low;
    assign sda_drive_low = own ? seq_sda_low : ctrl_sda_low;
endmodule

// File: rtl/unstick_chk.sv
`timescale 1ns/1ps
module unstick_chk #(
    parameter int RST_CYC = 16
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic ctrl_rst,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic ctrl_scl_low,
    input logic ctrl_sda_low,
    input logic target_rst_req,
    input logic timeout_flag,
    input logic scl_f
);
    logic [15:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run <= '0;
        else if (ctrl_rst) run <= run + 16'd1;
        else               run <= '0;
    end

    // R1
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_drive_low == ctrl_scl_low) && (sda_drive_low == ctrl_sda_low));

    // R3
    rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rst |-> busy && !scl_drive_low && !sda_drive_low);

    // R3
    rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rst && run != 16'd0) |-> run == 16'(RST_CYC));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    tgt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(target_rst_req) |-> busy && !scl_f);

    // R9
    tgt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (target_rst_req && scl_f && !busy) |=> !target_rst_req);

    // R7
    tmo_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |-> !$past(scl_f));
endmodule

bind bus_unstick_ctrl unstick_chk #(.RST_CYC(RST_CYC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy           (busy),
    .done           (done),
    .ctrl_rst       (ctrl_rst),
    .scl_drive_low  (scl_drive_low),
    .sda_drive_low  (sda_drive_low),
    .ctrl_scl_low   (ctrl_scl_low),
    .ctrl_sda_low   (ctrl_sda_low),
    .target_rst_req (target_rst_req),
    .timeout_flag   (timeout_flag),
    .scl_f          (scl_f)
);

// File: tb/test_bus_unstick_ctrl.sv
`timescale 1ns/1ps
module test_bus_unstick_ctrl;
    localparam int PHASE = 20;
    localparam int PULSES = 9;
    localparam int FILT = 4;
    localparam int RSTC = 8;
    localparam int TMO = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_scl_low = 1'b0, ctrl_sda_low = 1'b0, recover_req = 1'b0;
    logic tgt_scl = 1'b0, tgt_sda = 1'b0, sda_glitch = 1'b0;
    int   rel_after = 0;
    logic scl_drive_low, sda_drive_low, ctrl_rst, target_rst_req, timeout_flag, busy, done;
    logic [1:0] result;
    logic scl_line, sda_line;

    int tests = 0, fails = 0;

    // monitor state
    logic clr = 1'b0;
    int pulse_cnt, rst_cyc, rst_pulses, done_cnt, stop_cnt, edges, cur_lo, first_lo;
    logic sda_rel, p_scl, p_rst, p_sda, p_line;
    logic [1:0] res_at_done;
    logic tgt_at_done;

    assign scl_line = !(scl_drive_low || tgt_scl);
    assign sda_line = !(sda_drive_low || (tgt_sda && !sda_rel) || sda_glitch);

    always #2.5 clk = ~clk;

    bus_unstick_ctrl #(
        .PHASE_CYC(PHASE), .PULSES(PULSES), .FILT_CYC(FILT), .RST_CYC(RSTC), .TMO_CYC(TMO)
    ) i_bus_unstick_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .ctrl_scl_low(ctrl_scl_low), .ctrl_sda_low(ctrl_sda_low), .recover_req(recover_req),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .ctrl_rst(ctrl_rst),
        .target_rst_req(target_rst_req), .timeout_flag(timeout_flag), .busy(busy),
        .done(done), .result(result)
    );

    always @(negedge clk) begin
        if (clr) begin
            pulse_cnt = 0; rst_cyc = 0; rst_pulses = 0; done_cnt = 0; stop_cnt = 0;
            edges = 0; sda_rel = 1'b0; cur_lo = 0; first_lo = 0;
        end else begin
            if (scl_drive_low && !p_scl && !sda_drive_low && busy) pulse_cnt++;
            if (ctrl_rst) rst_cyc++;
            if (ctrl_rst && !p_rst) rst_pulses++;
            if (done) begin done_cnt++; res_at_done = result; tgt_at_done = target_rst_req; end
            if (!sda_drive_low && p_sda && !scl_drive_low) stop_cnt++;
            if (scl_line && !p_line) begin
                edges++;
                if (rel_after != 0 && edges == rel_after) sda_rel = 1'b1;
            end
            if (scl_drive_low && !sda_drive_low && busy) cur_lo++;
            else if (p_scl && !scl_drive_low) begin
                if (first_lo == 0) first_lo = cur_lo;
                cur_lo = 0;
            end
        end
        p_scl = scl_drive_low; p_rst = ctrl_rst; p_sda = sda_drive_low; p_line = scl_line;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk) recover_req = 1'b1;
        @(negedge clk) recover_req = 1'b0;
    endtask

    task automatic wait_done(input int maxc);
        for (int i = 0; i < maxc && done_cnt == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!scl_drive_low && !sda_drive_low, "R1 reset drives", int'(scl_drive_low), 0);
        chk(!ctrl_rst && !busy && !done, "R11 reset idle", int'(busy), 0);
        chk(result == 2'd0 && !target_rst_req && !timeout_flag, "R9 reset flags",
            int'(target_rst_req), 0);
    endtask

    task automatic t_passthru();
        @(negedge clk) ctrl_scl_low = 1'b1; ctrl_sda_low = 1'b0;
        @(negedge clk);
        chk(scl_drive_low && !sda_drive_low, "R1 scl passthru", int'(scl_drive_low), 1);
        repeat (TMO / 2) @(negedge clk);
        chk(!timeout_flag, "R7 short low no timeout", int'(timeout_flag), 0);
        ctrl_scl_low = 1'b0; ctrl_sda_low = 1'b1;
        @(negedge clk);
        chk(!scl_drive_low && sda_drive_low, "R1 sda passthru", int'(sda_drive_low), 1);
        ctrl_sda_low = 1'b0;
        repeat (FILT + 6) @(negedge clk);
    endtask

    task automatic t_sda_release(input int after, input string tag);
        clear_mon();
        tgt_sda = 1'b1; rel_after = after;
        repeat (FILT + 6) @(negedge clk);
        pulse_req();
        wait_done(2000);
        chk(pulse_cnt == PULSES, {tag, " R4 pulse count"}, pulse_cnt, PULSES);
        chk(first_lo == PHASE, "R4 low phase length", first_lo, PHASE);
        chk(stop_cnt == 1, "R5 stop issued", stop_cnt, 1);
        chk(res_at_done == 2'd0 && rst_pulses == 0, "R5 result released",
            int'(res_at_done), 0);
        chk(done_cnt == 1 && !busy, "R11 single done", done_cnt, 1);
        tgt_sda = 1'b0; rel_after = 0;
    endtask

    task automatic t_sda_stuck();
        clear_mon();
        tgt_sda = 1'b1; rel_after = 0;
        repeat (FILT + 6) @(negedge clk);
        pulse_req();
        repeat (3 * PHASE) @(negedge clk);
        pulse_req();   // R10 request while busy
        wait_done(2000);
        repeat (20) @(negedge clk);
        chk(pulse_cnt == PULSES, "R6 pulses before giving up", pulse_cnt, PULSES);
        chk(rst_pulses == 1 && rst_cyc == RSTC, "R6 reset pulse", rst_cyc, RSTC);
        chk(stop_cnt == 0, "R6 no stop", stop_cnt, 0);
        chk(res_at_done == 2'd1 && !tgt_at_done, "R6 result sda stuck", int'(res_at_done), 1);
        chk(done_cnt == 1, "R10 busy request ignored", done_cnt, 1);
        tgt_sda = 1'b0;
        repeat (FILT + 6) @(negedge clk);
    endtask

    task automatic t_scl_stuck();
        clear_mon();
        tgt_scl = 1'b1;
        repeat (FILT + 6) @(negedge clk);
        pulse_req();
        wait_done(500);
        chk(pulse_cnt == 0, "R3 no clocking", pulse_cnt, 0);
        chk(rst_cyc == RSTC && rst_pulses == 1, "R3 reset length", rst_cyc, RSTC);
        chk(res_at_done == 2'd2, "R3 result scl stuck", int'(res_at_done), 2);
        chk(tgt_at_done && target_rst_req, "R9 target reset req", int'(target_rst_req), 1);
        tgt_scl = 1'b0;
        repeat (FILT + 6) @(negedge clk);
        chk(!target_rst_req, "R9 req clears on release", int'(target_rst_req), 0);
    endtask

    task automatic t_timeout();
        int n = 0;
        clear_mon();
        tgt_scl = 1'b1;
        while (!timeout_flag && n < 2 * TMO) begin @(negedge clk); n++; end
        chk(n >= TMO && n <= TMO + FILT + 4, "R7 timeout delay", n, TMO + FILT + 2);
        wait_done(500);
        chk(res_at_done == 2'd3 && pulse_cnt == 0, "R8 timeout result", int'(res_at_done), 3);
        chk(rst_pulses == 1 && rst_cyc == RSTC, "R8 reset on timeout", rst_cyc, RSTC);
        chk(target_rst_req, "R9 target req after timeout", int'(target_rst_req), 1);
        tgt_scl = 1'b0;
        repeat (FILT + 6) @(negedge clk);
        chk(!timeout_flag && !target_rst_req, "R7 flag clears", int'(timeout_flag), 0);
    endtask

    task automatic t_clean_bus();
        clear_mon();
        pulse_req();
        wait_done(500);
        chk(pulse_cnt == 0 && rst_pulses == 0, "R12 no pulses no reset", pulse_cnt, 0);
        chk(stop_cnt == 1 && res_at_done == 2'd0, "R12 stop on clean bus", stop_cnt, 1);
    endtask

    task automatic t_glitch();
        clear_mon();
        @(negedge clk) sda_glitch = 1'b1;
        @(negedge clk) recover_req = 1'b1;
        @(negedge clk) recover_req = 1'b0;
        repeat (FILT - 3) @(negedge clk);
        sda_glitch = 1'b0;
        wait_done(500);
        chk(pulse_cnt == 0, "R2 glitch ignored", pulse_cnt, 0);
        chk(res_at_done == 2'd0 && stop_cnt == 1, "R2 glitch result", int'(res_at_done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthru();
        t_clean_bus();
        t_sda_release(3, "first");
        t_sda_release(3, "retry R10");
        t_sda_stuck();
        t_scl_stuck();
        t_timeout();
        t_glitch();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule